// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Unit

This block holds a joint translation buffer of 2-way set-associative entries, 128 sets by default. Software drives it through four registers: two descriptor words, an index register and a command register. The first descriptor word carries the page-aligned virtual page number, a valid flag and an 8-bit address-space identifier. The second carries the frame number and the permission bits, which the unit stores without interpreting them. A write to the command register starts one operation:

- read an entry back;
- store an entry, with or without a micro-TLB flush;
- search for a translation;
- pick a slot for a new translation;
- flush the micro-TLBs only.

The usual miss-handler sequence is as follows. Load the first descriptor and probe for it. If the probe fails, ask for a slot. Load the second descriptor, then store the entry. The store that leaves the micro-TLBs untouched suits refills. The flushing store, or the explicit flush command, is for removing translations. A lookup that finds nothing, and a lookup that finds the same translation in two ways, each report a separate error code in the index register. Duplicate entries are therefore caught when they are looked up, not when they are written.

Top module: `tlb_cmd_unit`

## Requirements
- R1: After a synchronous reset the descriptor outputs and the index output read 0, busy and the flush output are low, every entry is invalid, and every round-robin pointer is 0.
- R2: While busy is low, a register write with reg_sel 0 loads descriptor word 0, 1 loads descriptor word 1, 2 loads the index register (low 16 bits) and 3 starts a command. Each value shows on its output one cycle later. A register write made while busy is high is ignored.
- R3: Any command write raises busy for exactly one cycle. The result of the command is visible in the cycle in which busy is low again.
- R4: Command code 2 stores both descriptor words at the entry addressed by the low 8 index bits (index = set × 2 + way). It raises utlb_flush for exactly one cycle.
- R5: Command code 5 stores the entry in the same way as code 2 but leaves utlb_flush low.
- R6: Command code 1 loads both descriptor registers from the entry at the current index.
- R7: Command code 3 looks in the set given by descriptor-0 bits [19:13] for a valid entry whose bits [31:13] and [7:0] equal descriptor 0. Bit 10 is the valid flag. On a single hit the index register becomes set × 2 + way.
- R8: A search that matches no way loads the index register with 16'h8000 (MSB set marks an error).
- R9: A search that matches more than one way loads the index register with 16'hC000.
- R10: Command code 4 loads the index register with set × 2 + way for the set given by descriptor 0. The way is the lowest invalid way, or the set's round-robin pointer when every way is valid.
- R11: The round-robin pointer of a set advances by one, modulo the way count, on every store (code 2 or 5) into that set.
- R12: Command code 6 raises utlb_flush for one cycle and changes no entry.
- R13: A read or store while index bit 15 is set does nothing: no flush, no store, and the descriptor registers are unchanged. Unlisted command codes change nothing either.
- R14: Storing all-zero descriptors at an index erases that entry, so a later search for the old translation misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 desc0, 1 desc1, 2 index, 3 command |
| reg_wdata | input | 32 | Register write data |
| pd0_o | output | 32 | Descriptor word 0 register |
| pd1_o | output | 32 | Descriptor word 1 register |
| index_o | output | 16 | Index register, bit 15 is the error flag |
| busy_o | output | 1 | High in the cycle a command is executing |
| utlb_flush_o | output | 1 | One-cycle flush pulse to the micro-TLBs |

## Verification
Some properties hold on every cycle, and the assertions check those. Busy never lasts two cycles. A flush pulse always traces back to a flushing store or the explicit flush command. The index register changes only through a command or a software write. The round-robin pointer of a set steps once per store into it. The slot chooser never passes over an invalid way. Other behaviour depends on what the array holds, and only the bench scenarios can show it. That includes whether a search finds the right way, the two distinct error codes, the victim order after erasures, reads after stores, and the absence of any effect from erroneous indexes and unknown codes. The bench fills all 256 entries and then searches for and reads back every one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int DW         = 32;
    localparam int IDX_W      = 16;
    localparam int PAGE_SHIFT = 13;
    localparam int VALID_BIT  = 10;
    localparam int ASID_W     = 8;
    localparam int TAG_W      = (DW - PAGE_SHIFT) + ASID_W;

    localparam logic [IDX_W-1:0] IDX_MISS = 16'h8000;
    localparam logic [IDX_W-1:0] IDX_DUP  = 16'hC000;

    typedef enum logic [3:0] {
        CMD_NOP      = 4'd0,
        CMD_READ     = 4'd1,
        CMD_WRITE    = 4'd2,
        CMD_PROBE    = 4'd3,
        CMD_GETIDX   = 4'd4,
        CMD_WRITE_NI = 4'd5,
        CMD_UFLUSH   = 4'd6
    } tlb_cmd_e;

    typedef enum logic [1:0] {
        RA_PD0 = 2'd0,
        RA_PD1 = 2'd1,
        RA_IDX = 2'd2,
        RA_CMD = 2'd3
    } tlb_reg_e;

    typedef struct packed {
        logic [DW-1:0] pd1;
        logic [DW-1:0] pd0;
    } tlb_entry_t;

    function automatic logic [TAG_W-1:0] pd0_tag(input logic [DW-1:0] p);
        return {p[DW-1:PAGE_SHIFT], p[ASID_W-1:0]};
    endfunction

    function automatic logic pd0_valid(input logic [DW-1:0] p);
        return p[VALID_BIT];
    endfunction

    function automatic tlb_cmd_e decode_cmd(input logic [3:0] c);
        tlb_cmd_e r;
        case (c)
            4'd1:    r = CMD_READ;
            4'd2:    r = CMD_WRITE;
            4'd3:    r = CMD_PROBE;
            4'd4:    r = CMD_GETIDX;
            4'd5:    r = CMD_WRITE_NI;
            4'd6:    r = CMD_UFLUSH;
            default: r = CMD_NOP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tlb_store.sv
module tlb_store
    import tlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 2,
    localparam int ENTRIES = SETS * WAYS,
    localparam int EA_W    = $clog2(ENTRIES),
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W   = EA_W - WAY_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [EA_W-1:0]           wr_addr,
    input  tlb_entry_t                wr_data,
    input  logic [EA_W-1:0]           rd_addr,
    output tlb_entry_t                rd_data,
    input  logic [SET_W-1:0]          set_sel,
    output tlb_entry_t [WAYS-1:0]     set_ways,
    output logic [WAY_W-1:0]          rr_ptr
);

    tlb_entry_t         mem   [ENTRIES];
    logic [WAY_W-1:0]   rr_q  [SETS];
    logic [SET_W-1:0]   wr_set;

    assign wr_set  = wr_addr[EA_W-1:WAY_W];
    assign rd_data = mem[rd_addr];
    assign rr_ptr  = rr_q[set_sel];

    for (genvar w = 0; w < WAYS; w++) begin : g_way_rd
        assign set_ways[w] = mem[{set_sel, WAY_W'(w)}];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
            for (int s = 0; s < SETS; s++)    rr_q[s] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
            rr_q[wr_set] <= rr_q[wr_set] + 1'b1;
        end
    end

    AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rr_q[$past(wr_set)] == WAY_W'($past(rr_q[wr_set]) + 1'b1))); // R11

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data))); // R4

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
    import tlb_pkg::*;
#(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  tlb_entry_t [WAYS-1:0] ways,
    input  logic [DW-1:0]         key,
    output logic                  hit,
    output logic                  dup,
    output logic [WAY_W-1:0]      way
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = pd0_valid(ways[w].pd0) &&
                          (pd0_tag(ways[w].pd0) == pd0_tag(key));
    end

    always_comb begin
        way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) way = WAY_W'(w);
        end
    end

    assign hit = |match;
    assign dup = ($countones(match) > 1);

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int WAYS = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tlb_entry_t [WAYS-1:0] ways,
    input  logic [WAY_W-1:0]      rr_ptr,
    output logic [WAY_W-1:0]      way
);

    logic [WAYS-1:0] vld;

    for (genvar w = 0; w < WAYS; w++) begin : g_vld
        assign vld[w] = pd0_valid(ways[w].pd0);
    end

    always_comb begin
        way = rr_ptr;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!vld[w]) way = WAY_W'(w);
        end
    end

    AST_PREFER_FREE: assert property (@(posedge clk) disable iff (rst)
        (vld != '1) |-> !vld[way]); // R10

endmodule

// File: rtl/tlb_cmd_unit.sv
module tlb_cmd_unit
    import tlb_pkg::*;
#(
    parameter int SETS = 128,
    parameter int WAYS = 2,
    localparam int ENTRIES = SETS * WAYS,
    localparam int EA_W    = $clog2(ENTRIES),
    localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int SET_W   = EA_W - WAY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       pd0_o,
    output logic [31:0]       pd1_o,
    output logic [15:0]       index_o,
    output logic              busy_o,
    output logic              utlb_flush_o
);

    logic [DW-1:0]     pd0_q, pd1_q;
    logic [IDX_W-1:0]  idx_q;
    logic              busy_q, flush_q;
    tlb_cmd_e          pend_q;

    logic [SET_W-1:0]      set_sel;
    logic                  idx_ok;
    logic [EA_W-1:0]       ent_addr;
    logic                  wr_en;
    tlb_entry_t            wr_data, rd_data;
    tlb_entry_t [WAYS-1:0] set_ways;
    logic [WAY_W-1:0]      rr_ptr, hit_way, vic_way;
    logic                  hit, dup;

    assign set_sel  = pd0_q[PAGE_SHIFT +: SET_W];
    assign idx_ok   = !idx_q[IDX_W-1];
    assign ent_addr = idx_q[EA_W-1:0];
    assign wr_data  = '{pd1: pd1_q, pd0: pd0_q};
    assign wr_en    = busy_q && idx_ok &&
                      (pend_q == CMD_WRITE || pend_q == CMD_WRITE_NI);

    tlb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (ent_addr),
        .wr_data  (wr_data),
        .rd_addr  (ent_addr),
        .rd_data  (rd_data),
        .set_sel  (set_sel),
        .set_ways (set_ways),
        .rr_ptr   (rr_ptr)
    );

    tlb_probe #(.WAYS(WAYS)) u_probe (
        .ways (set_ways),
        .key  (pd0_q),
        .hit  (hit),
        .dup  (dup),
        .way  (hit_way)
    );

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .clk    (clk),
        .rst    (rst),
        .ways   (set_ways),
        .rr_ptr (rr_ptr),
        .way    (vic_way)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pd0_q   <= '0;
            pd1_q   <= '0;
            idx_q   <= '0;
            busy_q  <= 1'b0;
            flush_q <= 1'b0;
            pend_q  <= CMD_NOP;
        end else begin
            flush_q <= 1'b0;
            if (busy_q) begin
                busy_q <= 1'b0;
                case (pend_q)
                    CMD_READ: if (idx_ok) begin
                        pd0_q <= rd_data.pd0;
                        pd1_q <= rd_data.pd1;
                    end
                    CMD_WRITE:  if (idx_ok) flush_q <= 1'b1;
                    CMD_PROBE: begin
                        if (dup)      idx_q <= IDX_DUP;
                        else if (hit) idx_q <= IDX_W'({set_sel, hit_way});
                        else          idx_q <= IDX_MISS;
                    end
                    CMD_GETIDX: idx_q   <= IDX_W'({set_sel, vic_way});
                    CMD_UFLUSH: flush_q <= 1'b1;
                    default: ;
                endcase
            end else if (reg_we) begin
                case (tlb_reg_e'(reg_sel))
                    RA_PD0: pd0_q <= reg_wdata;
                    RA_PD1: pd1_q <= reg_wdata;
                    RA_IDX: idx_q <= reg_wdata[IDX_W-1:0];
                    RA_CMD: begin
                        pend_q <= decode_cmd(reg_wdata[3:0]);
                        busy_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pd0_o        = pd0_q;
    assign pd1_o        = pd1_q;
    assign index_o      = idx_q;
    assign busy_o       = busy_q;
    assign utlb_flush_o = flush_q;

    AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o); // R3

    AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (rst)
        utlb_flush_o |-> ($past(busy_q) &&
            ($past(pend_q) == CMD_UFLUSH ||
             ($past(pend_q) == CMD_WRITE && !$past(idx_q[IDX_W-1]))))); // R12

    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
        utlb_flush_o |=> !utlb_flush_o); // R4

    AST_IDX_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !$stable(index_o) |-> ($past(busy_q) ||
            $past(reg_we && reg_sel == RA_IDX))); // R2

    AST_PD_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_q && pend_q != CMD_READ) |=> ($stable(pd0_o) && $stable(pd1_o))); // R13

endmodule

// File: tb/tb_tlb_cmd_unit.sv
`timescale 1ns/1ps
module tb_tlb_cmd_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] pd0_o, pd1_o;
    logic [15:0] index_o;
    logic        busy_o, utlb_flush_o;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    tlb_cmd_unit dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .pd0_o(pd0_o), .pd1_o(pd1_o),
        .index_o(index_o), .busy_o(busy_o), .utlb_flush_o(utlb_flush_o)
    );

    function automatic logic [31:0] mk_pd0(input int i);
        return (32'((i % 2) + 1) << 20) | (32'(i / 2) << 13) | 32'h400 |
               32'((i * 37) & 255);
    endfunction

    function automatic logic [31:0] mk_pd1(input int i);
        return (32'(i) * 32'h01010101) ^ 32'hA500_0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // returns flush value seen in the result cycle
    task automatic do_cmd(input logic [3:0] code, output logic fl);
        reg_wr(2'd3, {28'd0, code});
        chk("R3 busy high", {31'd0, busy_o}, 32'd1);
        @(negedge clk);
        chk("R3 busy low", {31'd0, busy_o}, 32'd0);
        fl = utlb_flush_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual expired expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic fl;
        logic [31:0] keep0, keep1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pd0", pd0_o, 0);
        chk("R1 pd1", pd1_o, 0);
        chk("R1 idx", {16'd0, index_o}, 0);
        chk("R1 busy", {31'd0, busy_o}, 0);
        chk("R1 flush", {31'd0, utlb_flush_o}, 0);
        reg_wr(2'd0, mk_pd0(0));
        chk("R2 pd0 load", pd0_o, mk_pd0(0));
        do_cmd(4'd3, fl);
        chk("R1 empty probe", {16'd0, index_o}, 32'h8000);

        // Fill every entry without flushing (R5)
        for (int i = 0; i < 256; i++) begin
            reg_wr(2'd0, mk_pd0(i));
            reg_wr(2'd1, mk_pd1(i));
            reg_wr(2'd2, 32'(i));
            do_cmd(4'd5, fl);
            chk("R5 no flush", {31'd0, fl}, 0);
        end
        // Probe every entry (R7)
        for (int i = 0; i < 256; i++) begin
            reg_wr(2'd0, mk_pd0(i));
            reg_wr(2'd2, 32'd0);
            do_cmd(4'd3, fl);
            chk("R7 probe hit", {16'd0, index_o}, 32'(i));
        end
        // Read every entry (R6)
        for (int i = 0; i < 256; i++) begin
            reg_wr(2'd0, 32'd0);
            reg_wr(2'd2, 32'(i));
            do_cmd(4'd1, fl);
            chk("R6 read pd0", pd0_o, mk_pd0(i));
            chk("R6 read pd1", pd1_o, mk_pd1(i));
        end

        // Victim choice with full set: rr of set 5 is 0 after two stores (R10, R11)
        reg_wr(2'd0, mk_pd0(10));
        reg_wr(2'd1, mk_pd1(10));
        do_cmd(4'd4, fl);
        chk("R10 getidx rr0", {16'd0, index_o}, 32'd10);
        do_cmd(4'd2, fl);
        chk("R4 flush on write", {31'd0, fl}, 1);
        @(negedge clk);
        chk("R4 flush one cycle", {31'd0, utlb_flush_o}, 0);
        do_cmd(4'd4, fl);
        chk("R11 rr advanced", {16'd0, index_o}, 32'd11);
        reg_wr(2'd0, mk_pd0(11));
        reg_wr(2'd1, mk_pd1(11));
        do_cmd(4'd2, fl);
        do_cmd(4'd4, fl);
        chk("R11 rr wraps", {16'd0, index_o}, 32'd10);

        // Erase way 0 of set 5 (R14), invalid preferred over rr=1 (R10)
        reg_wr(2'd2, 32'd10);
        reg_wr(2'd0, 32'd0);
        reg_wr(2'd1, 32'd0);
        do_cmd(4'd2, fl);
        reg_wr(2'd0, mk_pd0(10));
        do_cmd(4'd4, fl);
        chk("R10 free way first", {16'd0, index_o}, 32'd10);
        do_cmd(4'd3, fl);
        chk("R14 erased miss", {16'd0, index_o}, 32'h8000);
        reg_wr(2'd0, mk_pd0(11));
        do_cmd(4'd3, fl);
        chk("R7 other way kept", {16'd0, index_o}, 32'd11);

        // Duplicate in set 10 (R9)
        reg_wr(2'd0, mk_pd0(20));
        reg_wr(2'd1, mk_pd1(20));
        reg_wr(2'd2, 32'd21);
        do_cmd(4'd5, fl);
        do_cmd(4'd3, fl);
        chk("R9 dup code", {16'd0, index_o}, 32'hC000);

        // ASID differs -> miss (R8)
        reg_wr(2'd0, mk_pd0(30) ^ 32'h1);
        do_cmd(4'd3, fl);
        chk("R8 asid miss", {16'd0, index_o}, 32'h8000);
        reg_wr(2'd0, mk_pd0(30) ^ 32'h0010_0000 ^ 32'h0020_0000 ^ 32'h0040_0000);
        do_cmd(4'd3, fl);
        chk("R8 vpn miss", {16'd0, index_o}, 32'h8000);

        // Explicit micro flush (R12)
        do_cmd(4'd6, fl);
        chk("R12 flush", {31'd0, fl}, 1);
        reg_wr(2'd2, 32'd30);
        do_cmd(4'd1, fl);
        chk("R12 entry kept pd0", pd0_o, mk_pd0(30));
        chk("R12 entry kept pd1", pd1_o, mk_pd1(30));

        // Error index: store and read do nothing (R13)
        reg_wr(2'd2, 32'h8000);
        reg_wr(2'd0, 32'd0);
        reg_wr(2'd1, 32'd0);
        do_cmd(4'd2, fl);
        chk("R13 no flush err idx", {31'd0, fl}, 0);
        do_cmd(4'd1, fl);
        chk("R13 read err idx", pd0_o, 32'd0);
        reg_wr(2'd2, 32'd40);
        do_cmd(4'd1, fl);
        chk("R13 entry intact", pd0_o, mk_pd0(40));

        // Unknown code (R13)
        keep0 = pd0_o; keep1 = pd1_o;
        do_cmd(4'd9, fl);
        chk("R13 unknown flush", {31'd0, fl}, 0);
        chk("R13 unknown pd0", pd0_o, keep0);
        chk("R13 unknown pd1", pd1_o, keep1);
        chk("R13 unknown idx", {16'd0, index_o}, 32'd40);

        // Register write during busy is ignored (R2)
        reg_wr(2'd2, 32'd41);
        reg_wr(2'd3, 32'd1);
        reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
        chk("R2 busy write ignored", pd1_o, mk_pd1(41));
        chk("R6 read under poke", pd0_o, mk_pd0(41));

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule